// File: doc/BRIEF.md
# Scanout Start Address Decomposer

This block turns a linear framebuffer start offset into a pixel-space origin for a scanout engine: the line to begin on (Y) and the pixel column within that line (X). The caller presents the raw offset register, the raw pitch register and a pixel depth code, then pulses a start strobe. The pitch register holds the line length in groups of 8 pixels. The block scales that length by the whole number of bytes each pixel occupies, which gives the line length in bytes. It then splits the byte offset into whole lines and a leftover byte count, and converts the leftover into pixels.

Both divisions run on one shared restoring divider that produces one quotient bit per clock. The block is therefore busy for a fixed number of cycles and then reports completion with a one-cycle done pulse. A start offset that does not land on a line boundary is allowed. It gives a non-zero column together with a misalignment flag.

Top module: `scan_origin_split`

## Requirements
- R1: After reset, busy_o, done_o and misalign_o are 0, and x_o and y_o are 0.
- R2: Only bits 26:0 of offset_i take part in the computation. Bits 31:27 have no effect on any result.
- R3: The line length in bytes is pitch_i[10:0] × 8 × bytes-per-pixel. y_o equals the masked offset divided by that length, rounded down.
- R4: The depth code on depth_i selects bytes per pixel as follows: 0 (8 bit) gives 1, 1 (15 bit) gives 2, 2 (16 bit) gives 2, 3 (24 bit) gives 3, and 4 (32 bit) gives 4. Any other code gives 1.
- R5: x_o equals (masked offset mod line bytes) divided by bytes per pixel, rounded down. misalign_o is 1 exactly when that remainder is non-zero, and an aligned offset gives x_o = 0.
- R6: A strobe accepted while idle with pitch_i[10:0] = 0 starts nothing. busy_o stays 0, no done pulse follows, and x_o, y_o and misalign_o keep their values.
- R7: busy_o is 1 from the cycle after an accepted strobe until the done pulse. done_o lasts exactly one cycle, with busy_o low. x_o, y_o and misalign_o change only together with done_o.
- R8: done_o is high in the cycle following the 56th rising edge after the edge that accepted the strobe, which is 2 × 27 + 2 edges.
- R9: A start strobe that arrives while busy_o is 1 is ignored. Neither the result nor the latency changes.
- R10: offset_i, pitch_i and depth_i are sampled only on the accepting edge. Later changes do not affect the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe |
| offset_i | input | 32 | Raw framebuffer start offset register, in bytes |
| pitch_i | input | 32 | Raw pitch register, in units of 8 pixels in bits 10:0 |
| depth_i | input | 3 | Pixel depth code |
| busy_o | output | 1 | Computation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| x_o | output | 14 | Start column in pixels |
| y_o | output | 27 | Start line |
| misalign_o | output | 1 | Offset not on a line boundary |

## Verification
The assertions assume that start_i, pitch_i and depth_i are driven to known values whenever reset is released. They also assume that a strobe seen while idle is meant as a request, so a strobe with a non-zero pitch field must raise busy on the next cycle. The stimulus changes inputs only on the falling clock edge and holds the strobe for a single cycle. It issues strobes during a busy period only in the scenarios that test rejection. It never gives a zero line length to the divider, because a zero pitch field is rejected before any division starts.

// File: rtl/scan_origin_pkg.sv
package scan_origin_pkg;

    typedef enum logic [2:0] {
        DEPTH_8  = 3'd0,
        DEPTH_15 = 3'd1,
        DEPTH_16 = 3'd2,
        DEPTH_24 = 3'd3,
        DEPTH_32 = 3'd4
    } depth_code_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ROW  = 2'd1,
        ST_COL  = 2'd2
    } ctl_state_e;

endpackage

// File: rtl/bpp_lookup.sv
module bpp_lookup
    import scan_origin_pkg::*;
(
    input  logic [2:0] depth_i,
    output logic [2:0] bpp_o
);

    always_comb begin
        case (depth_i)
            DEPTH_8:  bpp_o = 3'd1;
            DEPTH_15: bpp_o = 3'd2;
            DEPTH_16: bpp_o = 3'd2;
            DEPTH_24: bpp_o = 3'd3;
            DEPTH_32: bpp_o = 3'd4;
            default:  bpp_o = 3'd1;
        endcase
    end

endmodule

// File: rtl/div_restoring.sv
module div_restoring #(
    parameter int N = 27,
    parameter int D = 17
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic [N-1:0] dividend_i,
    input  logic [D-1:0] divisor_i,
    output logic         done_o,
    output logic [N-1:0] quot_o,
    output logic [D-1:0] rem_o
);

    localparam int CNT_W = $clog2(N + 1);

    typedef struct packed {
        logic [N-1:0]     quo;
        logic [D-1:0]     rem;
        logic [D-1:0]     dvs;
        logic [CNT_W-1:0] cnt;
        logic             done;
    } div_reg_t;

    div_reg_t q, d;
    logic [D:0] shifted_w;
    logic [D:0] diff_w;
    logic       take_w;

    always_comb begin
        d         = q;
        d.done    = 1'b0;
        shifted_w = {q.rem, q.quo[N-1]};
        diff_w    = shifted_w - {1'b0, q.dvs};
        take_w    = (shifted_w >= {1'b0, q.dvs});
        if (start_i) begin
            d.quo = dividend_i;
            d.rem = '0;
            d.dvs = divisor_i;
            d.cnt = CNT_W'(N);
        end else if (q.cnt != '0) begin
            d.rem = take_w ? diff_w[D-1:0] : shifted_w[D-1:0];
            d.quo = {q.quo[N-2:0], take_w};
            d.cnt = q.cnt - 1'b1;
            if (q.cnt == CNT_W'(1)) begin
                d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign done_o = q.done;
    assign quot_o = q.quo;
    assign rem_o  = q.rem;

endmodule

// File: rtl/scan_origin_split.sv
module scan_origin_split
    import scan_origin_pkg::*;
#(
    parameter int REG_W   = 32,
    parameter int OFS_W   = 27,
    parameter int PITCH_W = 11,
    localparam int X_W    = PITCH_W + 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [REG_W-1:0] offset_i,
    input  logic [REG_W-1:0] pitch_i,
    input  logic [2:0]       depth_i,
    output logic             busy_o,
    output logic             done_o,
    output logic [X_W-1:0]   x_o,
    output logic [OFS_W-1:0] y_o,
    output logic             misalign_o
);

    localparam int PIX_W    = PITCH_W + 3;
    localparam int STRIDE_W = PIX_W + 3;
    localparam logic [REG_W-1:0] OFS_MASK   = REG_W'((64'd1 << OFS_W) - 64'd1);
    localparam logic [REG_W-1:0] PITCH_MASK = REG_W'((64'd1 << PITCH_W) - 64'd1);

    typedef struct packed {
        ctl_state_e       st;
        logic [2:0]       bpp;
        logic [X_W-1:0]   x;
        logic [OFS_W-1:0] y;
        logic             mis;
        logic             done;
    } ctl_reg_t;

    ctl_reg_t q, d;

    logic [OFS_W-1:0]    ofs_masked;
    logic [PITCH_W-1:0]  pitch_fld;
    logic [PIX_W-1:0]    pix_w;
    logic [2:0]          bpp_in;
    logic [STRIDE_W-1:0] stride_in;
    logic                pitch_nz;

    logic                div_start;
    logic [OFS_W-1:0]    div_dvd;
    logic [STRIDE_W-1:0] div_dvs;
    logic                div_done;
    logic [OFS_W-1:0]    div_quot;
    logic [STRIDE_W-1:0] div_rem;

    assign ofs_masked = OFS_W'(offset_i & OFS_MASK);
    assign pitch_fld  = PITCH_W'(pitch_i & PITCH_MASK);
    assign pitch_nz   = (pitch_fld != '0);
    assign pix_w      = {pitch_fld, 3'b000};
    assign stride_in  = STRIDE_W'(pix_w) * STRIDE_W'(bpp_in);

    bpp_lookup i_bpp_lookup (
        .depth_i (depth_i),
        .bpp_o   (bpp_in)
    );

    div_restoring #(
        .N (OFS_W),
        .D (STRIDE_W)
    ) i_div_restoring (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (div_start),
        .dividend_i (div_dvd),
        .divisor_i  (div_dvs),
        .done_o     (div_done),
        .quot_o     (div_quot),
        .rem_o      (div_rem)
    );

    // Phase one: offset / line bytes. Phase two: leftover bytes / bytes per pixel.
    always_comb begin
        d         = q;
        d.done    = 1'b0;
        div_start = 1'b0;
        div_dvd   = ofs_masked;
        div_dvs   = stride_in;
        case (q.st)
            ST_IDLE: begin
                if (start_i && pitch_nz) begin
                    div_start = 1'b1;
                    d.bpp     = bpp_in;
                    d.st      = ST_ROW;
                end
            end
            ST_ROW: begin
                div_dvd = OFS_W'(div_rem);
                div_dvs = STRIDE_W'(q.bpp);
                if (div_done) begin
                    div_start = 1'b1;
                    d.st      = ST_COL;
                end
            end
            ST_COL: begin
                if (div_done) begin
                    d.x    = div_quot[X_W-1:0];
                    d.mis  = (div_quot != '0) || (div_rem != '0);
                    d.done = 1'b1;
                    d.st   = ST_IDLE;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    // Row result is captured when phase one ends; it stays hidden until done.
    logic [OFS_W-1:0] y_pend_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q        <= '{st: ST_IDLE, default: '0};
            y_pend_q <= '0;
        end else begin
            q <= d;
            if (q.st == ST_ROW && div_done) begin
                y_pend_q <= div_quot;
            end
            if (q.st == ST_COL && div_done) begin
                q.y <= y_pend_q;
            end
        end
    end

    assign busy_o     = (q.st != ST_IDLE);
    assign done_o     = q.done;
    assign x_o        = q.x;
    assign y_o        = q.y;
    assign misalign_o = q.mis;

endmodule

// File: rtl/scan_origin_split_chk.sv
module scan_origin_split_chk #(
    parameter int REG_W   = 32,
    parameter int OFS_W   = 27,
    parameter int PITCH_W = 11,
    localparam int X_W    = PITCH_W + 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic [REG_W-1:0] pitch_i,
    input logic             busy_o,
    input logic             done_o,
    input logic [X_W-1:0]   x_o,
    input logic [OFS_W-1:0] y_o,
    input logic             misalign_o
);

    localparam logic [REG_W-1:0] PMASK = REG_W'((64'd1 << PITCH_W) - 64'd1);

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R7

    AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && $past(busy_o))); // R7

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> ($stable(x_o) && $stable(y_o) && $stable(misalign_o))); // R7

    AST_ALIGNED_ZERO_X: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !misalign_o) |-> (x_o == '0)); // R5

    AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && ((pitch_i & PMASK) != '0)) |=> busy_o); // R7

    AST_ZERO_PITCH_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && ((pitch_i & PMASK) == '0)) |=> !busy_o); // R6

endmodule

bind scan_origin_split scan_origin_split_chk #(
    .REG_W   (REG_W),
    .OFS_W   (OFS_W),
    .PITCH_W (PITCH_W)
) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .pitch_i    (pitch_i),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .x_o        (x_o),
    .y_o        (y_o),
    .misalign_o (misalign_o)
);

// File: tb/test_scan_origin_split.sv
module test_scan_origin_split;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [31:0] offset_i = '0;
    logic [31:0] pitch_i = '0;
    logic [2:0]  depth_i = '0;
    logic        busy_o, done_o, misalign_o;
    logic [13:0] x_o;
    logic [26:0] y_o;

    int checks = 0;
    int errors = 0;
    localparam int LATENCY = 56;

    always #10 clk = ~clk;

    scan_origin_split i_scan_origin_split (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .offset_i(offset_i),
        .pitch_i(pitch_i), .depth_i(depth_i), .busy_o(busy_o), .done_o(done_o),
        .x_o(x_o), .y_o(y_o), .misalign_o(misalign_o)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic longint bpp_of(input logic [2:0] dc);
        case (dc)
            3'd1, 3'd2: return 2;
            3'd3:       return 3;
            3'd4:       return 4;
            default:    return 1;
        endcase
    endfunction

    task automatic model(input logic [31:0] off, input logic [31:0] p, input logic [2:0] dc,
                         output longint y, output longint x, output bit mis);
        longint b = bpp_of(dc);
        longint stride = longint'(p & 32'h7FF) * 8 * b;
        longint o = longint'(off & 32'h07FF_FFFF);
        longint r = o % stride;
        y = o / stride;
        x = r / b;
        mis = (r != 0);
    endtask

    task automatic launch(input logic [31:0] off, input logic [31:0] p, input logic [2:0] dc);
        @(negedge clk);
        offset_i = off; pitch_i = p; depth_i = dc; start_i = 1'b1;
        @(posedge clk);
        #1 start_i = 1'b0;
    endtask

    task automatic wait_done(output int n);
        n = 0;
        while (!done_o && n < 300) begin
            @(posedge clk);
            #1 n++;
        end
    endtask

    task automatic check_result(input string req, input logic [31:0] off,
                                input logic [31:0] p, input logic [2:0] dc, input int n);
        longint ey, ex;
        bit em;
        model(off, p, dc, ey, ex, em);
        chk(done_o == 1'b1, {req, " done"}, done_o, 1);
        chk(n == LATENCY, "R8 latency", n, LATENCY);
        chk(longint'(y_o) == ey, {req, " y"}, y_o, ey);
        chk(longint'(x_o) == ex, {req, " x"}, x_o, ex);
        chk(misalign_o == em, {req, " misalign"}, misalign_o, em);
        chk(busy_o == 1'b0, "R7 busy low at done", busy_o, 0);
        @(posedge clk);
        #1 chk(done_o == 1'b0, "R7 done one cycle", done_o, 0);
    endtask

    task automatic t_reset;
        #1;
        chk(busy_o == 0 && done_o == 0 && misalign_o == 0, "R1 flags", {busy_o, done_o, misalign_o}, 0);
        chk(x_o == 0 && y_o == 0, "R1 offsets", {x_o, y_o}, 0);
    endtask

    task automatic t_case(input string req, input logic [31:0] off,
                          input logic [31:0] p, input logic [2:0] dc);
        int n;
        launch(off, p, dc);
        chk(busy_o == 1'b1, "R7 busy after strobe", busy_o, 1);
        wait_done(n);
        check_result(req, off, p, dc, n);
    endtask

    task automatic t_zero_pitch;
        logic [13:0] px = x_o;
        logic [26:0] py = y_o;
        logic        pm = misalign_o;
        bit          saw = 1'b0;
        launch(32'd1234, 32'h0000_F800, 3'd4);
        repeat (70) begin
            @(posedge clk);
            #1 if (busy_o || done_o) saw = 1'b1;
        end
        chk(!saw, "R6 no busy or done", saw, 0);
        chk(x_o == px && y_o == py && misalign_o == pm, "R6 outputs kept", y_o, py);
    endtask

    task automatic t_restart;
        int n;
        launch(32'd3205, 32'd100, 3'd4);
        repeat (5) @(posedge clk);
        @(negedge clk);
        offset_i = 32'd77; pitch_i = 32'd3; depth_i = 3'd0; start_i = 1'b1;
        @(posedge clk);
        #1 start_i = 1'b0;
        wait_done(n);
        n = n + 6;
        check_result("R9 restart ignored", 32'd3205, 32'd100, 3'd4, n);
    endtask

    task automatic t_operand_change;
        int n;
        launch(32'd1000, 32'd4, 3'd3);
        offset_i = 32'd999_999; pitch_i = 32'd1; depth_i = 3'd0;
        wait_done(n);
        check_result("R10 sampled once", 32'd1000, 32'd4, 3'd3, n);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        t_reset();
        @(negedge clk) rst_n = 1'b1;
        t_case("R3 aligned 8bpp", 32'd64000, 32'd80, 3'd0);
        t_case("R5 misaligned 32bpp", 32'd22454, 32'd100, 3'd4);
        t_case("R5 24bpp remainder", 32'd367, 32'd5, 3'd3);
        t_case("R4 15bpp code", 32'd5003, 32'd10, 3'd1);
        t_case("R4 16bpp code", 32'd4801, 32'd12, 3'd2);
        t_case("R4 unknown code", 32'd4801, 32'd12, 3'd7);
        t_case("R2 upper bits masked", 32'hF800_1234, 32'd2, 3'd0);
        t_case("R3 max offset", 32'h07FF_FFFF, 32'd1, 3'd0);
        t_case("R3 max pitch", 32'h0123_4567, 32'hFFFF_FFFF, 3'd4);
        t_zero_pitch();
        t_restart();
        t_operand_change();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #2_000_000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule